// File: doc/BRIEF.md
# Memory Access Permission Checker with Bus Fault Capture

This block inspects each memory access issued by the processor or by the DMA engine and decides in the same cycle whether the access may proceed. It looks at the access address, the direction, the size, the privilege state and the page entry bits that the address translation unit supplies. An access is refused in four cases: the page is absent, a user-mode access reaches the I/O region, a user-mode access reaches the kernel region, or a write targets a page that is not writable. The checks are evaluated in a fixed priority order.

When an access is refused, the block records a 16-bit fault status word and two 16-bit bus status words. The fault status word encodes the fault class, the direction, the initiator and the parity-interrupt enable. The bus status words hold the initiator, the byte lane and the faulting address. A processor fault produces a one-cycle bus error strobe. A DMA fault produces a one-cycle level-7 interrupt strobe. Both strobes are gated by the error-enable control bit.

The captured words freeze at the first fault and stay frozen until software writes the clear-status register. A refused read returns all-ones data to the requester.

Top module: `bus_fault_guard`

## Requirements
- R1: After reset, the fault status word, bus status 0 and bus status 1 all read 0xFFFF, and both strobes are low.
- R2: A valid access whose address is below 0x400000 and whose page status is 0 is refused as a page fault. This check applies in supervisor mode as well, and it takes priority over every other check.
- R3: Unless R2 applies, a supervisor-mode access is always granted, at any address.
- R4: A user-mode access at or above 0x400000 is refused as a region fault.
- R5: A user-mode access below 0x400000 with address bits [22:19] all zero is refused as a kernel fault.
- R6: A user-mode write to a page whose write-enable bit is 0 is refused with the same code as a kernel fault. A user-mode read of such a page is granted.
- R7: Processor fault codes are as follows.
  - Write: 0x8BFF for a page fault, 0x9AFF for a region fault, 0x9BFF for a kernel or write-protect fault.
  - Read: 0xCBFF, 0xDAFF and 0xDBFF for the same three classes.
- R8: While the parity-interrupt enable is 1, the captured fault status word has 0x0400 ORed in.
- R9: For a processor fault, bus status 0 is set as follows, with address bits [23:16] ORed into the low byte. Size encoding: 0 is byte, 1 is word, 2 is long.
  - 0x7C00 for word or long accesses.
  - 0x7D00 for a byte access at an even address.
  - 0x7E00 for a byte access at an odd address.
- R10: For a DMA fault, the codes are 0xABFF, 0xBAFF and 0xBBFF for page, region and kernel/write-protect faults, with 0x4000 ORed in for reads. Bus status 0 is 0x3C00 ORed with address bits [23:16].
- R11: In the cycle after a fault, the bus error strobe is high for a processor fault and the level-7 strobe is high for a DMA fault, each for exactly one cycle. Neither strobe rises while error enable is 0, but the status words are still captured.
- R12: A refused read returns 0xFFFFFFFF on the read data output. A granted access passes the memory read data through unchanged.
- R13: After one fault has been captured, later faults leave all three status words unchanged until the next clear. Their strobes still fire.
- R14: A clear-status write sets all three words to 0xFFFF and re-arms capture. A fault in the same cycle as the clear is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 24 | Access address before translation |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| acc_dma | input | 1 | Access comes from the DMA engine |
| sup_mode | input | 1 | Processor is in supervisor mode |
| page_status | input | 2 | Page entry status bits, 0 means not present |
| page_wen | input | 1 | Page entry write-enable bit |
| err_en | input | 1 | Error enable, gates both strobes |
| par_ie | input | 1 | Parity-interrupt enable, reflected in the status word |
| clr_stat | input | 1 | Clear-status register write |
| rd_data_i | input | 32 | Read data from memory |
| acc_grant | output | 1 | Access allowed (combinational) |
| rd_data_o | output | 32 | Read data to the requester, all ones when refused |
| genstat_o | output | 16 | Captured fault status word |
| bsr0_o | output | 16 | Captured bus status 0 (initiator, lane, address high) |
| bsr1_o | output | 16 | Captured bus status 1 (address low) |
| bus_err_o | output | 1 | One-cycle processor bus error strobe |
| lvl7_o | output | 1 | One-cycle level-7 interrupt strobe for DMA faults |

## Verification
The check chain is tried with accesses that each fail exactly one rule in turn:
- A missing page in supervisor mode shows that the page check outranks the supervisor grant.
- A user access above the RAM region, a user access into the kernel region, and a user write to a read-only page each produce their own code.
- A read of that same read-only page confirms that write protection only refuses writes.

Byte accesses at odd and even addresses, word and long sizes, and processor versus DMA initiators separate the bus status 0 encodings. Runs with parity-interrupt enable high and error enable low separate the OR term and the strobe gating from the fault classification. A second fault with no clear in between, and a fault that coincides with a clear, show the capture-once behaviour and the clear priority.

// File: rtl/bus_fault_guard.sv
module bus_fault_guard #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic              acc_dma,
  input  logic              sup_mode,
  input  logic [1:0]        page_status,
  input  logic              page_wen,
  input  logic              err_en,
  input  logic              par_ie,
  input  logic              clr_stat,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              acc_grant,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] genstat_o,
  output logic [STAT_W-1:0] bsr0_o,
  output logic [STAT_W-1:0] bsr1_o,
  output logic              bus_err_o,
  output logic              lvl7_o
);
  localparam logic [ADDR_W-1:0] IO_BASE = ADDR_W'(24'h40_0000);
  localparam logic [STAT_W-1:0] ALL_ONES = '1;

  logic in_ram, kern_area, pf, uie, kern, nowe, fault, armed;
  logic [7:0] b0_hi;
  logic [STAT_W-1:0] gs_next, b0_next;

  assign in_ram    = acc_addr < IO_BASE;
  assign kern_area = acc_addr[22:19] == 4'd0;

  // priority chain: page presence, supervisor grant, region, kernel, write-protect
  assign pf   = in_ram && page_status == 2'd0;
  assign uie  = !pf && !sup_mode && !in_ram;
  assign kern = !pf && !sup_mode && in_ram && kern_area;
  assign nowe = !pf && !sup_mode && in_ram && !kern_area && acc_write && !page_wen;

  assign fault     = acc_valid && (pf || uie || kern || nowe);
  assign acc_grant = acc_valid && !fault;
  assign rd_data_o = fault ? '1 : rd_data_i;

  assign gs_next = {1'b1, !acc_write, acc_dma, !pf, 1'b1, par_ie, 1'b1, !uie, 8'hFF};

  always_comb begin
    if (acc_dma)             b0_hi = 8'h3C;
    else if (acc_size != 0)  b0_hi = 8'h7C;
    else if (acc_addr[0])    b0_hi = 8'h7E;
    else                     b0_hi = 8'h7D;
  end
  assign b0_next = {b0_hi, acc_addr[23:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      genstat_o <= ALL_ONES;
      bsr0_o    <= ALL_ONES;
      bsr1_o    <= ALL_ONES;
      armed     <= 1'b1;
      bus_err_o <= 1'b0;
      lvl7_o    <= 1'b0;
    end else begin
      bus_err_o <= fault && err_en && !acc_dma;
      lvl7_o    <= fault && err_en && acc_dma;
      if (clr_stat) begin
        genstat_o <= ALL_ONES;
        bsr0_o    <= ALL_ONES;
        bsr1_o    <= ALL_ONES;
        armed     <= 1'b1;
      end else if (fault && armed) begin
        genstat_o <= gs_next;
        bsr0_o    <= b0_next;
        bsr1_o    <= acc_addr[15:0];
        armed     <= 1'b0;
      end
    end
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_err_o, lvl7_o}));

  // R11
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_grant && err_en) |=> (bus_err_o || lvl7_o));

  // R14
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |=> (genstat_o == ALL_ONES && bsr0_o == ALL_ONES && bsr1_o == ALL_ONES));

  // R13
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !clr_stat) |=> $stable({genstat_o, bsr0_o, bsr1_o}));

  // R3
  sup_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sup_mode && !in_ram) |-> acc_grant);

  // R12
  rd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_grant) |-> rd_data_o == '1);
endmodule

// File: tb/test_bus_fault_guard.sv
module test_bus_fault_guard;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_dma = 0, sup_mode = 0, page_wen = 0;
  logic err_en = 1, par_ie = 0, clr_stat = 0;
  logic [23:0] acc_addr = 0;
  logic [1:0] acc_size = 0, page_status = 0;
  logic [31:0] rd_data_i = 32'h1234_5678;
  logic acc_grant, bus_err_o, lvl7_o;
  logic [31:0] rd_data_o;
  logic [15:0] genstat_o, bsr0_o, bsr1_o;
  int checks = 0, errors = 0;

  bus_fault_guard i_bus_fault_guard (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_acc(string tag, bit dma, bit wr, bit [1:0] sz, bit [23:0] a, bit sup,
                        bit [1:0] pst, bit wen, bit exp_g, bit [15:0] egs, bit [15:0] eb0,
                        bit [15:0] eb1, bit ebe, bit el7, bit clr = 0);
    @(negedge clk);
    acc_valid = 1; acc_dma = dma; acc_write = wr; acc_size = sz; acc_addr = a;
    sup_mode = sup; page_status = pst; page_wen = wen; clr_stat = clr;
    #2;
    chk({tag, " grant"}, acc_grant, exp_g);
    if (!wr) chk({tag, " R12 rdata"}, rd_data_o, exp_g ? 32'h1234_5678 : 32'hFFFF_FFFF);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0; clr_stat = 0;
    chk({tag, " genstat"}, genstat_o, egs);
    chk({tag, " bsr0"}, bsr0_o, eb0);
    chk({tag, " bsr1"}, bsr1_o, eb1);
    chk({tag, " R11 buserr"}, bus_err_o, ebe);
    chk({tag, " R11 lvl7"}, lvl7_o, el7);
  endtask

  task automatic do_clear();
    @(negedge clk); clr_stat = 1;
    @(negedge clk); clr_stat = 0;
    chk("R14 clear genstat", genstat_o, 16'hFFFF);
    chk("R14 clear bsr0", bsr0_o, 16'hFFFF);
    chk("R14 clear bsr1", bsr1_o, 16'hFFFF);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 genstat", genstat_o, 16'hFFFF);
    chk("R1 bsr0", bsr0_o, 16'hFFFF);
    chk("R1 bsr1", bsr1_o, 16'hFFFF);
    chk("R1 strobes", {bus_err_o, lvl7_o}, 0);
  endtask

  initial begin
    t_reset();
    do_acc("R3 user ok", 0, 0, 1, 24'h080000, 0, 2, 1, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0);
    do_acc("R2 R7 R9 odd byte rd", 0, 0, 0, 24'h123457, 0, 0, 1, 0, 16'hCBFF, 16'h7E12, 16'h3457, 1, 0);
    do_acc("R13 hold", 0, 0, 1, 24'h500000, 0, 2, 1, 0, 16'hCBFF, 16'h7E12, 16'h3457, 1, 0);
    do_clear();
    do_acc("R2 sup pf wr", 0, 1, 1, 24'h000100, 1, 0, 1, 0, 16'h8BFF, 16'h7C00, 16'h0100, 1, 0);
    do_clear();
    do_acc("R3 sup io", 0, 1, 1, 24'h500000, 1, 2, 0, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0);
    par_ie = 1;
    do_acc("R4 R8 user io wr", 0, 1, 1, 24'h600000, 0, 2, 1, 0, 16'h9EFF, 16'h7C60, 16'h0000, 1, 0);
    par_ie = 0;
    do_clear();
    do_acc("R5 R9 kernel even byte", 0, 0, 0, 24'h040002, 0, 1, 1, 0, 16'hDBFF, 16'h7D04, 16'h0002, 1, 0);
    do_clear();
    do_acc("R6 ro read", 0, 0, 2, 24'h100000, 0, 3, 0, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0);
    do_acc("R6 ro write", 0, 1, 2, 24'h100000, 0, 3, 0, 0, 16'h9BFF, 16'h7C10, 16'h0000, 1, 0);
    do_clear();
    par_ie = 1;
    do_acc("R10 dma rd pf", 1, 0, 1, 24'h2ABCDE, 0, 0, 1, 0, 16'hEFFF, 16'h3C2A, 16'hBCDE, 0, 1);
    par_ie = 0;
    do_clear();
    do_acc("R10 dma wr io", 1, 1, 1, 24'h700004, 0, 2, 1, 0, 16'hBAFF, 16'h3C70, 16'h0004, 0, 1);
    do_clear();
    err_en = 0;
    do_acc("R11 masked", 0, 1, 1, 24'h000010, 0, 2, 1, 0, 16'h9BFF, 16'h7C00, 16'h0010, 0, 0);
    err_en = 1;
    do_acc("R14 clr wins", 0, 1, 1, 24'h600000, 0, 2, 1, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1, 0, 1);
    do_acc("R14 rearmed", 0, 0, 1, 24'h600000, 0, 2, 1, 0, 16'hDAFF, 16'h7C60, 16'h0000, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule